// File: doc/BRIEF.md
# BCD Decade Up/Down Counter

A single-decade synchronous counter that holds one decimal digit (0 to 9) in four bits. A two-bit operation select chooses between loading a new digit from a parallel input, stepping upward, stepping downward, or freezing the present value. Every state change happens on the rising clock edge. An active-low count enable (carry-in) gates stepping, and an active-low carry-out flags the digit's terminal value in the selected direction. Feeding one digit's carry-out into the next digit's carry-in builds a multi-digit decimal counter with no extra logic.

The carry-out is decoded combinationally from the stored digit, the operation select and the carry-in. It is not a registered flag, so a freshly loaded digit drives it at once. The six unused codes (10 to 15) can enter only through a load. From any of them, a fixed recovery path returns the counter to the decimal sequence within two enabled steps in either direction. A synchronous active-high reset clears the digit.

Top module: `bcd_decade_counter`

## Requirements
- R1: While `rst` is high at a rising edge, `count_q` becomes 0 at that edge.
- R2: With `mode_sel` = 2'b00 (load), the value on `load_data` is stored into `count_q` at the rising edge, for all 16 codes. Selecting load without a clock edge leaves `count_q` unchanged.
- R3: With `mode_sel` = 2'b01 (up) and `carry_in_n` low, each edge steps a legal digit by +1, and 9 wraps to 0.
- R4: With `mode_sel` = 2'b10 (down) and `carry_in_n` low, each edge steps a legal digit by -1, and 0 wraps to 9.
- R5: With `mode_sel` = 2'b11 (hold), `count_q` keeps its value across edges.
- R6: With `carry_in_n` high, `count_q` keeps its value in up and down modes.
- R7: In up mode with `carry_in_n` low, `carry_out_n` is low exactly when `count_q` is 9.
- R8: In down mode with `carry_in_n` low, `carry_out_n` is low exactly when `count_q` is 0.
- R9: `carry_out_n` is high in load and hold modes, and whenever `carry_in_n` is high.
- R10: Counting up from an unused code follows 10→11, 11→6, 12→13, 13→4, 14→15, 15→0, so a legal digit is reached within two steps.
- R11: Counting down from an unused code follows 10→9, 11→10, 12→3, 13→12, 14→5, 15→14, so a legal digit is reached within two steps.
- R12: Two counters, with the low digit's `carry_out_n` wired to the high digit's `carry_in_n` and a shared `mode_sel`, count 00 to 99 with wrap to 00 going up, and wrap from 00 to 99 going down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset to digit 0 |
| mode_sel | input | 2 | Operation: 00 load, 01 up, 10 down, 11 hold |
| carry_in_n | input | 1 | Active-low count enable from a lower digit |
| load_data | input | DIGIT_W | Parallel value stored in load mode |
| count_q | output | DIGIT_W | Present digit |
| carry_out_n | output | 1 | Active-low terminal-count flag toward a higher digit |

## Verification
The bench builds the counter at its default four-bit digit width. At that width all sixteen codes can be swept: every code is loaded, and every unused code is stepped in both directions and followed until it becomes legal. Two instances are chained through the carry pair, which brings the full 00–99 cycle in both directions within reach. That cycle covers every carry hand-off, including the wrap from 00 to 99 going down.

// File: rtl/bcd_ctr_pkg.sv
`timescale 1ns/1ps
package bcd_ctr_pkg;

  typedef enum logic [1:0] {
    OP_LOAD = 2'b00,
    OP_UP   = 2'b01,
    OP_DOWN = 2'b10,
    OP_HOLD = 2'b11
  } op_e;

  localparam int unsigned DEC_TOP = 9;

endpackage

// File: rtl/bcd_op_decode.sv
`timescale 1ns/1ps
module bcd_op_decode
  import bcd_ctr_pkg::*;
(
  input  logic [1:0] mode_sel,
  input  logic       carry_in_n,
  output logic       do_load,
  output logic       up_sel,
  output logic       down_sel,
  output logic       step_up,
  output logic       step_down
);

  op_e op;

  always_comb begin
    op        = op_e'(mode_sel);
    do_load   = (op == OP_LOAD);
    up_sel    = (op == OP_UP);
    down_sel  = (op == OP_DOWN);
    step_up   = up_sel   && !carry_in_n;
    step_down = down_sel && !carry_in_n;
  end

endmodule

// File: rtl/bcd_step_logic.sv
`timescale 1ns/1ps
module bcd_step_logic
  import bcd_ctr_pkg::*;
#(
  parameter int unsigned DIGIT_W = 4
) (
  input  logic [DIGIT_W-1:0] cur,
  input  logic [DIGIT_W-1:0] load_data,
  input  logic               do_load,
  input  logic               step_up,
  input  logic               step_down,
  output logic [DIGIT_W-1:0] nxt
);

  localparam logic [DIGIT_W-1:0] TOP  = DIGIT_W'(DEC_TOP);
  localparam logic [DIGIT_W-1:0] ZERO = '0;
  localparam logic [DIGIT_W-1:0] ONE  = DIGIT_W'(1);

  logic [DIGIT_W-1:0] up_val;
  logic [DIGIT_W-1:0] dn_val;

  // Upward successor, including the recovery path for unused codes
  always_comb begin
    if (cur < TOP) begin
      up_val = cur + ONE;
    end else if (cur == TOP) begin
      up_val = ZERO;
    end else begin
      case (cur)
        DIGIT_W'(10): up_val = DIGIT_W'(11);
        DIGIT_W'(11): up_val = DIGIT_W'(6);
        DIGIT_W'(12): up_val = DIGIT_W'(13);
        DIGIT_W'(13): up_val = DIGIT_W'(4);
        DIGIT_W'(14): up_val = DIGIT_W'(15);
        default:      up_val = ZERO;
      endcase
    end
  end

  // Downward successor, including the recovery path for unused codes
  always_comb begin
    if (cur == ZERO) begin
      dn_val = TOP;
    end else if (cur <= TOP) begin
      dn_val = cur - ONE;
    end else begin
      case (cur)
        DIGIT_W'(10): dn_val = DIGIT_W'(9);
        DIGIT_W'(11): dn_val = DIGIT_W'(10);
        DIGIT_W'(12): dn_val = DIGIT_W'(3);
        DIGIT_W'(13): dn_val = DIGIT_W'(12);
        DIGIT_W'(14): dn_val = DIGIT_W'(5);
        default:      dn_val = DIGIT_W'(14);
      endcase
    end
  end

  always_comb begin
    if (do_load)        nxt = load_data;
    else if (step_up)   nxt = up_val;
    else if (step_down) nxt = dn_val;
    else                nxt = cur;
  end

endmodule

// File: rtl/bcd_term_detect.sv
`timescale 1ns/1ps
module bcd_term_detect
  import bcd_ctr_pkg::*;
#(
  parameter int unsigned DIGIT_W = 4
) (
  input  logic [DIGIT_W-1:0] cur,
  input  logic               up_sel,
  input  logic               down_sel,
  input  logic               carry_in_n,
  output logic               carry_out_n
);

  logic at_top;
  logic at_zero;

  always_comb begin
    at_top      = (cur == DIGIT_W'(DEC_TOP));
    at_zero     = (cur == '0);
    carry_out_n = !(!carry_in_n && ((up_sel && at_top) || (down_sel && at_zero)));
  end

endmodule

// File: rtl/bcd_decade_counter.sv
`timescale 1ns/1ps
module bcd_decade_counter
  import bcd_ctr_pkg::*;
#(
  parameter int unsigned DIGIT_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         mode_sel,
  input  logic               carry_in_n,
  input  logic [DIGIT_W-1:0] load_data,
  output logic [DIGIT_W-1:0] count_q,
  output logic               carry_out_n
);

  localparam logic [DIGIT_W-1:0] TOP = DIGIT_W'(DEC_TOP);

  logic               do_load;
  logic               up_sel;
  logic               down_sel;
  logic               step_up;
  logic               step_down;
  logic [DIGIT_W-1:0] digit_nxt;
  logic [DIGIT_W-1:0] digit_r;

  bcd_op_decode u_dec (
    .mode_sel   (mode_sel),
    .carry_in_n (carry_in_n),
    .do_load    (do_load),
    .up_sel     (up_sel),
    .down_sel   (down_sel),
    .step_up    (step_up),
    .step_down  (step_down)
  );

  bcd_step_logic #(.DIGIT_W(DIGIT_W)) u_step (
    .cur       (digit_r),
    .load_data (load_data),
    .do_load   (do_load),
    .step_up   (step_up),
    .step_down (step_down),
    .nxt       (digit_nxt)
  );

  bcd_term_detect #(.DIGIT_W(DIGIT_W)) u_term (
    .cur         (digit_r),
    .up_sel      (up_sel),
    .down_sel    (down_sel),
    .carry_in_n  (carry_in_n),
    .carry_out_n (carry_out_n)
  );

  always_ff @(posedge clk) begin
    if (rst) digit_r <= '0;
    else     digit_r <= digit_nxt;
  end

  assign count_q = digit_r;

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (count_q == '0));

  // R2
  load_take_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'b00) |=> (count_q == $past(load_data)));

  // R5
  hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'b11) |=> $stable(count_q));

  // R6
  cin_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_sel[1] != mode_sel[0] && carry_in_n) |=> $stable(count_q));

  // R3
  up_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'b01 && !carry_in_n && count_q == TOP) |=> (count_q == '0));

  // R4
  down_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'b10 && !carry_in_n && count_q == '0) |=> (count_q == TOP));

  // R9
  carry_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_sel[1] == mode_sel[0] || carry_in_n) |-> carry_out_n);

  // R10
  up_recover_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'b01 && !carry_in_n && count_q > TOP && count_q[0]) |=> (count_q <= TOP));

  // R11
  down_recover_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'b10 && !carry_in_n && count_q > TOP && !count_q[0]) |=> (count_q <= TOP));

endmodule

// File: tb/bcd_decade_counter_tb.sv
`timescale 1ns/1ps
module bcd_decade_counter_tb;

  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] mode;
  logic       cin_n;
  logic [3:0] din;
  logic [3:0] q_lo, q_hi;
  logic       co_lo, co_hi;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  bcd_decade_counter #(.DIGIT_W(4)) u_dut (
    .clk(clk), .rst(rst), .mode_sel(mode), .carry_in_n(cin_n),
    .load_data(din), .count_q(q_lo), .carry_out_n(co_lo)
  );

  bcd_decade_counter #(.DIGIT_W(4)) u_hi (
    .clk(clk), .rst(rst), .mode_sel(mode), .carry_in_n(co_lo),
    .load_data(din), .count_q(q_hi), .carry_out_n(co_hi)
  );

  function automatic int up_next(int c);
    if (c < 9)  return c + 1;
    if (c == 9) return 0;
    case (c)
      10: return 11; 11: return 6; 12: return 13;
      13: return 4;  14: return 15; default: return 0;
    endcase
  endfunction

  function automatic int dn_next(int c);
    if (c == 0) return 9;
    if (c <= 9) return c - 1;
    case (c)
      10: return 9;  11: return 10; 12: return 3;
      13: return 12; 14: return 5;  default: return 14;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // advance one edge; inputs and samples sit 1 ns after the edge
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      finish_run();
    end
  end

  initial begin
    int e;
    rst = 1; mode = 2'b11; cin_n = 1; din = 0;
    step(); step();
    // R1 reset state
    chk(q_lo == 0, "R1", q_lo, 0);
    chk(q_hi == 0, "R1", q_hi, 0);
    rst = 0;

    // R2 / R9 load every code
    mode = 2'b00; cin_n = 0;
    for (int c = 0; c < 16; c++) begin
      din = 4'(c);
      step();
      chk(q_lo == 4'(c), "R2", q_lo, c);
      chk(co_lo == 1'b1, "R9", co_lo, 1);
    end
    // R2 selecting load without an edge does not load
    din = 4'd3; step();
    din = 4'd7; #2;
    chk(q_lo == 4'd3, "R2", q_lo, 3);
    #2; step();
    chk(q_lo == 4'd7, "R2", q_lo, 7);

    // R3 / R7 count up over two full wraps
    din = 0; step();
    mode = 2'b01; cin_n = 0; e = 0;
    for (int i = 0; i < 20; i++) begin
      chk(co_lo == (e == 9 ? 1'b0 : 1'b1), "R7", co_lo, (e == 9) ? 0 : 1);
      step();
      e = up_next(e);
      chk(q_lo == 4'(e), "R3", q_lo, e);
    end

    // R4 / R8 count down
    for (int i = 0; i < 20; i++) begin
      mode = 2'b10; #0;
      chk(co_lo == (e == 0 ? 1'b0 : 1'b1), "R8", co_lo, (e == 0) ? 0 : 1);
      step();
      e = dn_next(e);
      chk(q_lo == 4'(e), "R4", q_lo, e);
    end

    // R5 / R9 hold mode
    mode = 2'b11;
    for (int i = 0; i < 3; i++) begin
      step();
      chk(q_lo == 4'(e), "R5", q_lo, e);
      chk(co_lo == 1'b1, "R9", co_lo, 1);
    end

    // R6 / R9 carry-in high blocks counting in both directions
    mode = 2'b00; din = 4'd9; step();
    mode = 2'b01; cin_n = 1; #0;
    chk(co_lo == 1'b1, "R9", co_lo, 1);
    step(); chk(q_lo == 4'd9, "R6", q_lo, 9);
    mode = 2'b10; step(); chk(q_lo == 4'd9, "R6", q_lo, 9);
    cin_n = 0;

    // R10 / R11 recovery from each unused code
    for (int c = 10; c < 16; c++) begin
      for (int d = 0; d < 2; d++) begin
        mode = 2'b00; din = 4'(c); step();
        mode = (d == 0) ? 2'b01 : 2'b10;
        e = (d == 0) ? up_next(c) : dn_next(c);
        step();
        chk(q_lo == 4'(e), (d == 0) ? "R10" : "R11", q_lo, e);
        step();
        chk(q_lo <= 4'd9, (d == 0) ? "R10" : "R11", q_lo, 9);
      end
    end

    // R12 two-digit cascade up then down
    rst = 1; mode = 2'b11; step(); rst = 0;
    mode = 2'b01; cin_n = 0;
    for (int i = 1; i <= 100; i++) begin
      step();
      chk(int'(q_hi) * 10 + int'(q_lo) == i % 100, "R12",
          int'(q_hi) * 10 + int'(q_lo), i % 100);
    end
    mode = 2'b10;
    for (int i = 1; i <= 100; i++) begin
      step();
      chk(int'(q_hi) * 10 + int'(q_lo) == (100 - i) % 100, "R12",
          int'(q_hi) * 10 + int'(q_lo), (100 - i) % 100);
    end

    done = 1;
    finish_run();
  end

endmodule